// File: doc/BRIEF.md
# Ordered Ingress Queue With Stalled-Request Side Lane

This block sits on the fabric-facing receive side of a bridge. It keeps every arriving packet in one ordered main queue, whatever its class: posted write, non-posted request or completion. Each packet is pushed together with a two-bit class tag and leaves through a valid/ready pop port. The side that consumes the pop port sorts packets into its own per-class queues. This buffer does not split traffic by class.

Two level inputs describe the state of the consumer. One says whether credits for non-posted requests are available. The other says whether credits for posted writes and completions are available. A request can reach the head of the main queue while request credits are missing. In that case the request moves into a small side lane, so that the writes and completions queued behind it can keep flowing. When request credits come back, the side lane is emptied before anything in the main queue is offered.

A pulse returns one credit to the link partner only after a buffer slot has really been freed. A configuration input selects when that happens. In the late setting the pulse follows a packet leaving the block. In the early setting it follows a packet leaving the main queue, either through a pop or through a move into the side lane. The sender's credit total should match the main queue depth.

Top module: `sqb_ingress`

## Requirements
- R1: `push_ready` is low exactly when the main queue holds MAIN_DEPTH packets. A push offered while it is low is discarded and never overwrites a stored packet.
- R2: The class tag is encoded as 2'b00 posted write, 2'b01 non-posted request and 2'b10 completion. When both credit inputs are high, packets of all classes leave in the order they arrived.
- R3: A non-posted request at the main head while `req_ok` is low moves into the side lane on the next clock edge if the lane is not full. The packet behind it then becomes the main head.
- R4: A posted write or completion at the main head is never moved to the side lane. It is offered only while `ord_ok` is high.
- R5: While the side lane is non-empty and `req_ok` is high, the pop port offers the side-lane head in preference to the main queue.
- R6: Packets in the side lane leave in the order in which they entered it.
- R7: With `cfg_early` low, `credit_ret` is high for exactly the cycle that follows each pop handshake. Moves into the side lane return no credit.
- R8: With `cfg_early` high, `credit_ret` is high for the cycle that follows each departure from the main queue, whether by pop or by move. A pop from the side lane returns no credit.
- R9: After reset, `pop_valid` and `credit_ret` are low and `push_ready` is high.
- R10: `pop_kind` and `pop_data` reproduce the pushed tag and payload unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_early | input | 1 | 1: credit on leaving the main queue, 0: credit on leaving the block |
| push_valid | input | 1 | Packet offered |
| push_kind | input | 2 | Class tag of the offered packet |
| push_data | input | DATA_W | Payload of the offered packet |
| push_ready | output | 1 | Main queue has room |
| pop_valid | output | 1 | A packet is offered downstream |
| pop_ready | input | 1 | Downstream takes the offered packet |
| pop_kind | output | 2 | Class tag of the offered packet |
| pop_data | output | DATA_W | Payload of the offered packet |
| req_ok | input | 1 | Credits for non-posted requests are available |
| ord_ok | input | 1 | Credits for posted writes and completions are available |
| credit_ret | output | 1 | One-cycle pulse returning one credit |

## Verification
Two events can fall in the same cycle: a push into the main queue and a head request moving into the side lane. Likewise, a side-lane pop can coincide with a main-queue request that is held back. The bench provokes the first case by pushing back to back while request credits are withheld. It then judges the result by the exact order in which packets leave: writes and completions overtake the stalled requests, and the requests follow in their own order once credits return. The second case is provoked by filling the side lane so that a third request waits at the main head. The bench then checks that the lane drains completely before that request is offered, and that each credit pulse lands on the cycle selected by `cfg_early`.

// File: rtl/sqb_pkg.sv
package sqb_pkg;
  typedef enum logic [1:0] {
    PKT_POSTED = 2'b00,
    PKT_NPREQ  = 2'b01,
    PKT_CPL    = 2'b10
  } pkt_kind_e;

  function automatic logic needs_req_credit(input pkt_kind_e k);
    return k == PKT_NPREQ;
  endfunction

  function automatic logic credit_event(input logic early, input logic main_leave,
                                        input logic any_pop);
    return early ? main_leave : any_pop;
  endfunction
endpackage

// File: rtl/sqb_fifo.sv
module sqb_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          wr_ok, rd_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign wr_ok   = wr_en && !full;
  assign rd_ok   = rd_en && !empty;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_ok) wr_ptr <= bump(wr_ptr);
      if (rd_ok) rd_ptr <= bump(rd_ptr);
      case ({wr_ok, rd_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/sqb_head_arb.sv
module sqb_head_arb
  import sqb_pkg::*;
(
  input  logic      main_empty,
  input  pkt_kind_e main_kind,
  input  logic      byp_empty,
  input  logic      byp_full,
  input  logic      req_ok,
  input  logic      ord_ok,
  input  logic      pop_ready,
  output logic      pop_valid,
  output logic      sel_byp,
  output logic      issue_byp,
  output logic      issue_main,
  output logic      move_byp
);
  logic byp_go, main_req, main_go;

  always_comb begin
    byp_go   = !byp_empty && req_ok;
    main_req = !main_empty && needs_req_credit(main_kind);
    main_go  = !main_empty && !byp_go && (main_req ? req_ok : ord_ok);
    move_byp = main_req && !req_ok && !byp_full;
    sel_byp    = byp_go;
    pop_valid  = byp_go || main_go;
    issue_byp  = byp_go && pop_ready;
    issue_main = main_go && pop_ready;
  end
endmodule

// File: rtl/sqb_credit_ret.sv
module sqb_credit_ret
  import sqb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_early,
  input  logic main_leave,
  input  logic any_pop,
  output logic credit_ret
);
  always_ff @(posedge clk) begin
    if (!rst_n) credit_ret <= 1'b0;
    else        credit_ret <= credit_event(cfg_early, main_leave, any_pop);
  end
endmodule

// File: rtl/sqb_ingress.sv
module sqb_ingress
  import sqb_pkg::*;
#(
  parameter int MAIN_DEPTH = 8,
  parameter int BYP_DEPTH  = 4,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_early,
  input  logic              push_valid,
  input  logic [1:0]        push_kind,
  input  logic [DATA_W-1:0] push_data,
  output logic              push_ready,
  output logic              pop_valid,
  input  logic              pop_ready,
  output logic [1:0]        pop_kind,
  output logic [DATA_W-1:0] pop_data,
  input  logic              req_ok,
  input  logic              ord_ok,
  output logic              credit_ret
);
  localparam int ENTRY_W = DATA_W + 2;

  logic [ENTRY_W-1:0] main_head, byp_head, out_entry;
  logic main_empty, main_full, byp_empty, byp_full;
  logic sel_byp, issue_byp, issue_main, move_byp;
  logic push_acc, main_leave, any_pop;
  logic [1:0] main_kind_w;

  assign push_ready  = !main_full;
  assign push_acc    = push_valid && push_ready;
  assign main_kind_w = main_head[ENTRY_W-1 -: 2];
  assign main_leave  = issue_main || move_byp;
  assign any_pop     = issue_main || issue_byp;

  sqb_fifo #(.DEPTH(MAIN_DEPTH), .W(ENTRY_W)) u_main (
    .clk(clk), .rst_n(rst_n),
    .wr_en(push_acc), .wr_data({push_kind, push_data}),
    .rd_en(main_leave), .rd_data(main_head),
    .empty(main_empty), .full(main_full)
  );

  sqb_fifo #(.DEPTH(BYP_DEPTH), .W(ENTRY_W)) u_byp (
    .clk(clk), .rst_n(rst_n),
    .wr_en(move_byp), .wr_data(main_head),
    .rd_en(issue_byp), .rd_data(byp_head),
    .empty(byp_empty), .full(byp_full)
  );

  sqb_head_arb u_arb (
    .main_empty(main_empty), .main_kind(pkt_kind_e'(main_kind_w)),
    .byp_empty(byp_empty), .byp_full(byp_full),
    .req_ok(req_ok), .ord_ok(ord_ok), .pop_ready(pop_ready),
    .pop_valid(pop_valid), .sel_byp(sel_byp),
    .issue_byp(issue_byp), .issue_main(issue_main), .move_byp(move_byp)
  );

  sqb_credit_ret u_cred (
    .clk(clk), .rst_n(rst_n), .cfg_early(cfg_early),
    .main_leave(main_leave), .any_pop(any_pop), .credit_ret(credit_ret)
  );

  assign out_entry = sel_byp ? byp_head : main_head;
  assign pop_kind  = out_entry[ENTRY_W-1 -: 2];
  assign pop_data  = out_entry[DATA_W-1:0];
endmodule

// File: rtl/sqb_ingress_chk.sv
module sqb_ingress_chk #(
  parameter int MAIN_DEPTH = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_early,
  input logic       push_valid,
  input logic       push_ready,
  input logic       pop_valid,
  input logic       pop_ready,
  input logic       req_ok,
  input logic       byp_empty,
  input logic       issue_byp,
  input logic       issue_main,
  input logic       move_byp,
  input logic       main_leave,
  input logic [1:0] main_kind,
  input logic       credit_ret
);
  logic [15:0] occ;

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else occ <= occ + 16'(push_valid && push_ready) - 16'(main_leave);
  end

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= 16'(MAIN_DEPTH));
  assert_full_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == 16'(MAIN_DEPTH)) |-> !push_ready);
  assert_one_action_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({issue_byp, issue_main, move_byp}));
  assert_move_only_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    move_byp |-> (main_kind == 2'b01));
  assert_lane_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!byp_empty && req_ok && pop_ready) |-> (issue_byp && !issue_main));
  assert_credit_late_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_early && pop_valid && pop_ready) |=> credit_ret);
  assert_credit_early_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_early && main_leave) |=> credit_ret);
endmodule

bind sqb_ingress sqb_ingress_chk #(.MAIN_DEPTH(MAIN_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_early(cfg_early),
  .push_valid(push_valid), .push_ready(push_ready),
  .pop_valid(pop_valid), .pop_ready(pop_ready), .req_ok(req_ok),
  .byp_empty(byp_empty), .issue_byp(issue_byp), .issue_main(issue_main),
  .move_byp(move_byp), .main_leave(main_leave), .main_kind(main_kind_w),
  .credit_ret(credit_ret)
);

// File: tb/sqb_ingress_test.sv
module sqb_ingress_test;
  localparam int MD = 4;
  localparam int BD = 2;
  localparam int DW = 8;
  localparam logic [1:0] KP = 2'b00, KN = 2'b01, KC = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_early = 1'b0;
  logic push_valid = 1'b0;
  logic [1:0] push_kind = 2'b00;
  logic [DW-1:0] push_data = '0;
  logic push_ready, pop_valid, credit_ret;
  logic pop_ready = 1'b0;
  logic [1:0] pop_kind;
  logic [DW-1:0] pop_data;
  logic req_ok = 1'b0;
  logic ord_ok = 1'b0;
  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sqb_ingress #(.MAIN_DEPTH(MD), .BYP_DEPTH(BD), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_early(cfg_early),
    .push_valid(push_valid), .push_kind(push_kind), .push_data(push_data),
    .push_ready(push_ready), .pop_valid(pop_valid), .pop_ready(pop_ready),
    .pop_kind(pop_kind), .pop_data(pop_data),
    .req_ok(req_ok), .ord_ok(ord_ok), .credit_ret(credit_ret)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [DW-1:0] d);
    @(negedge clk);
    push_valid = 1'b1; push_kind = k; push_data = d;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic pop_exp(input logic [1:0] k, input logic [DW-1:0] d,
                         input logic cr, input string tag);
    int waits = 0;
    while (!pop_valid && waits < 8) begin
      @(negedge clk);
      waits++;
    end
    check({tag, " valid"}, 32'(pop_valid), 32'd1);
    check({tag, " R10 kind"}, 32'(pop_kind), 32'(k));
    check({tag, " R10 data"}, 32'(pop_data), 32'(d));
    pop_ready = 1'b1;
    @(negedge clk);
    pop_ready = 1'b0;
    check({tag, " credit"}, 32'(credit_ret), 32'(cr));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset values
    check("R9 pop_valid", 32'(pop_valid), 0);
    check("R9 push_ready", 32'(push_ready), 1);
    check("R9 credit_ret", 32'(credit_ret), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R4: fill with writes and completions while ord credits are withheld
    push(KP, 8'h01); push(KC, 8'h02); push(KP, 8'h03); push(KC, 8'h04);
    check("R1 full push_ready", 32'(push_ready), 0);
    check("R4 head waits for ord_ok", 32'(pop_valid), 0);
    push(KP, 8'h99);
    ord_ok = 1'b1;
    pop_exp(KP, 8'h01, 1'b1, "R1 R7 p1");
    pop_exp(KC, 8'h02, 1'b1, "R2 R7 p2");
    pop_exp(KP, 8'h03, 1'b1, "R2 p3");
    pop_exp(KC, 8'h04, 1'b1, "R2 p4");
    @(negedge clk);
    check("R1 refused push not stored", 32'(pop_valid), 0);

    // R2 mixed classes with both credits available
    req_ok = 1'b1;
    push(KP, 8'h10); push(KN, 8'h11); push(KC, 8'h12); push(KN, 8'h13);
    pop_exp(KP, 8'h10, 1'b1, "R2 m0");
    pop_exp(KN, 8'h11, 1'b1, "R2 m1");
    pop_exp(KC, 8'h12, 1'b1, "R2 m2");
    pop_exp(KN, 8'h13, 1'b1, "R2 m3");

    // R3 / R6 / R7: stalled requests step aside, ordered traffic passes
    req_ok = 1'b0;
    push(KN, 8'h20); push(KP, 8'h21); push(KN, 8'h22); push(KC, 8'h23);
    repeat (3) @(negedge clk);
    check("R7 no credit on move", 32'(credit_ret), 0);
    pop_exp(KP, 8'h21, 1'b1, "R3 pass1");
    pop_exp(KC, 8'h23, 1'b1, "R3 pass2");
    repeat (2) @(negedge clk);
    check("R3 lane held without req_ok", 32'(pop_valid), 0);
    req_ok = 1'b1;
    pop_exp(KN, 8'h20, 1'b1, "R6 lane0");
    pop_exp(KN, 8'h22, 1'b1, "R6 lane1");

    // R5: full lane drains before a request waiting at the main head
    req_ok = 1'b0; ord_ok = 1'b0;
    push(KN, 8'h30); push(KN, 8'h31); push(KN, 8'h32); push(KP, 8'h33);
    repeat (3) @(negedge clk);
    check("R4 nothing offered", 32'(pop_valid), 0);
    check("R1 room left", 32'(push_ready), 1);
    req_ok = 1'b1; ord_ok = 1'b1;
    pop_exp(KN, 8'h30, 1'b1, "R5 first");
    pop_exp(KN, 8'h31, 1'b1, "R5 R6 second");
    pop_exp(KN, 8'h32, 1'b1, "R5 main req");
    pop_exp(KP, 8'h33, 1'b1, "R5 tail");

    // R8: early credit point
    @(negedge clk);
    cfg_early = 1'b1; req_ok = 1'b0;
    push(KN, 8'h40);
    @(negedge clk);
    check("R8 credit on move", 32'(credit_ret), 1);
    @(negedge clk);
    check("R8 single pulse", 32'(credit_ret), 0);
    push(KP, 8'h41);
    pop_exp(KP, 8'h41, 1'b1, "R8 main pop");
    req_ok = 1'b1;
    pop_exp(KN, 8'h40, 1'b0, "R8 lane pop");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule